// File: doc/BRIEF.md
# Subroutine Frame Stack Controller

This block keeps a small hardware program stack that a simple processor core uses for two things: plain data pushes and pops, and a three-step subroutine linkage made of mark-frame, call and return. The core presents one operation strobe per cycle, together with push data, a call target and the address of the instruction after the call. The block updates its stack and frame pointers, hands back popped data, and tells fetch where to go next on a call or a return.

Mark-frame reserves a return-address slot before any parameters are pushed. The slot's index is kept in a frame register, and the index of the enclosing frame is saved inside the slot. A later call writes the return address into that reserved slot rather than on top of the stack. The callee can therefore pop its parameters first. Return cuts the stack back to just below the slot, redirects to the stored address and restores the outer frame. Entries live in an internal array. The stack grows toward lower indices from an empty value equal to the depth.

Top module: `frame_stack_ctl`

## Requirements
- R1: After reset, sp_o equals DEPTH (empty, 16 by default), and pop_valid_o, pc_valid_o, ovf_o, udf_o, pop_data_o and pc_o are all zero.
- R2: An accepted push lowers sp_o by one and stores push_data_i at the new top. An accepted pop raises sp_o by one. The cycle after the pop, it drives the top value on pop_data_o with a one-cycle pop_valid_o pulse, giving last-in first-out order. pop_data_o holds its value until the next accepted pop.
- R3: A push or mark-frame while sp_o is 0 (full) gives a one-cycle ovf_o pulse the next cycle. It leaves sp_o and the stored entries unchanged.
- R4: A pop while the stack is empty, or while the top entry is the current frame slot, gives a one-cycle udf_o pulse the next cycle. It leaves sp_o, the frame and the stored entries unchanged.
- R5: Mark-frame lowers sp_o by one, reserves the new top entry as the current frame slot and saves the previous frame index in that slot.
- R6: A call with an open frame writes ret_addr_i into the current frame slot without changing sp_o. The next cycle it drives call_target_i on pc_o with a one-cycle pc_valid_o pulse. pc_o holds its value until the next redirect.
- R7: A call with no open frame is ignored: no pc_valid_o, no flag, and sp_o unchanged.
- R8: A return with an open frame sets sp_o to the frame slot index plus one, which discards the slot and everything above it. The next cycle it drives the stored return address on pc_o with pc_valid_o, and it reinstates the enclosing frame so nested calls unwind in order.
- R9: A return with no open frame gives a one-cycle udf_o pulse and otherwise has no effect.
- R10: When several strobes are high in one cycle, only one operation is performed, chosen in the priority order return, call, mark-frame, pop, push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| mark_i | input | 1 | Mark-frame strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| push_data_i | input | WIDTH | Value to push |
| call_target_i | input | WIDTH | Subroutine entry address |
| ret_addr_i | input | WIDTH | Address of the instruction after the call |
| pop_data_o | output | WIDTH | Last popped value |
| pop_valid_o | output | 1 | Pulse: pop_data_o updated |
| sp_o | output | $clog2(DEPTH+1) | Stack pointer (DEPTH means empty) |
| pc_o | output | WIDTH | Redirect address for call or return |
| pc_valid_o | output | 1 | Pulse: pc_o updated |
| ovf_o | output | 1 | Pulse: push or mark-frame refused on a full stack |
| udf_o | output | 1 | Pulse: pop or return refused |

## Verification
The checker's single-operation properties assume that, when they fire, only the named strobe is high. The other properties make no assumption about how many strobes are high. The bench drives mostly single strobes, and drives the overlapping cases only in the dedicated priority steps, where the reference model applies the same priority order. The stimulus covers filling the stack to full, popping across an empty stack and against a frame slot, and nesting two frames, so the flag and unwind properties are all reached.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_MARK = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5
  } stk_op_e;
endpackage

// File: rtl/fsc_decode.sv
module fsc_decode
  import fsc_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    mark_i,
  input  logic    call_i,
  input  logic    ret_i,
  output stk_op_e op_o
);
  // R10: fixed priority, return highest
  always_comb begin
    if (ret_i)       op_o = OP_RET;
    else if (call_i) op_o = OP_CALL;
    else if (mark_i) op_o = OP_MARK;
    else if (pop_i)  op_o = OP_POP;
    else if (push_i) op_o = OP_PUSH;
    else             op_o = OP_NONE;
  end
endmodule

// File: rtl/fsc_store.sv
module fsc_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             we_val_i,
  input  logic             we_link_i,
  input  logic [IW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wval_i,
  input  logic [IW-1:0]    wlink_i,
  input  logic [IW-1:0]    raddr_top_i,
  input  logic [IW-1:0]    raddr_frm_i,
  output logic [WIDTH-1:0] top_val_o,
  output logic [WIDTH-1:0] frm_val_o,
  output logic [IW-1:0]    frm_link_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LIMIT = IW'(DEPTH);

  logic [WIDTH-1:0] val_q  [DEPTH];
  logic [IW-1:0]    link_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_val_i && waddr_i == IW'(i))  val_q[i]  <= wval_i;
      if (we_link_i && waddr_i == IW'(i)) link_q[i] <= wlink_i;
    end
  end

  // reads of the empty sentinel return zero
  always_comb begin
    top_val_o  = '0;
    frm_val_o  = '0;
    frm_link_o = LIMIT;
    if (raddr_top_i < LIMIT) top_val_o = val_q[raddr_top_i[AW-1:0]];
    if (raddr_frm_i < LIMIT) begin
      frm_val_o  = val_q[raddr_frm_i[AW-1:0]];
      frm_link_o = link_q[raddr_frm_i[AW-1:0]];
    end
  end
endmodule

// File: rtl/fsc_ptr.sv
module fsc_ptr
  import fsc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic [WIDTH-1:0] ret_addr_i,
  input  logic [IW-1:0]    frm_link_i,
  output logic [IW-1:0]    sp_o,
  output logic [IW-1:0]    fp_o,
  output logic             we_val_o,
  output logic             we_link_o,
  output logic [IW-1:0]    waddr_o,
  output logic [WIDTH-1:0] wval_o,
  output logic [IW-1:0]    wlink_o,
  output logic             ovf_o,
  output logic             udf_o,
  output logic             pop_ok_o,
  output logic             pc_ok_o
);
  localparam logic [IW-1:0] NONE = IW'(DEPTH);

  logic [IW-1:0] sp_q, sp_d, fp_q, fp_d, sp_dec, sp_inc;
  logic full, empty, no_frame;

  assign full     = (sp_q == '0);
  assign empty    = (sp_q == NONE);
  assign no_frame = (fp_q == NONE);
  assign sp_dec   = sp_q - 1'b1;
  assign sp_inc   = sp_q + 1'b1;

  always_comb begin
    sp_d      = sp_q;
    fp_d      = fp_q;
    we_val_o  = 1'b0;
    we_link_o = 1'b0;
    waddr_o   = sp_dec;
    wval_o    = push_data_i;
    wlink_o   = NONE;
    ovf_o     = 1'b0;
    udf_o     = 1'b0;
    pop_ok_o  = 1'b0;
    pc_ok_o   = 1'b0;
    unique case (op_i)
      OP_PUSH: begin
        if (full) ovf_o = 1'b1;
        else begin
          sp_d      = sp_dec;
          we_val_o  = 1'b1;
          we_link_o = 1'b1;
        end
      end
      OP_MARK: begin
        if (full) ovf_o = 1'b1;
        else begin
          sp_d      = sp_dec;
          fp_d      = sp_dec;
          we_val_o  = 1'b1;
          we_link_o = 1'b1;
          wval_o    = '0;
          wlink_o   = fp_q;
        end
      end
      OP_POP: begin
        // the frame slot is not poppable data
        if (empty || sp_q == fp_q) udf_o = 1'b1;
        else begin
          sp_d     = sp_inc;
          pop_ok_o = 1'b1;
        end
      end
      OP_CALL: begin
        if (!no_frame) begin
          we_val_o = 1'b1;
          waddr_o  = fp_q;
          wval_o   = ret_addr_i;
          pc_ok_o  = 1'b1;
        end
      end
      OP_RET: begin
        if (no_frame) udf_o = 1'b1;
        else begin
          sp_d    = fp_q + 1'b1;
          fp_d    = frm_link_i;
          pc_ok_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= NONE;
      fp_q <= NONE;
    end else begin
      sp_q <= sp_d;
      fp_q <= fp_d;
    end
  end

  assign sp_o = sp_q;
  assign fp_o = fp_q;
endmodule

// File: rtl/frame_stack_ctl.sv
module frame_stack_ctl
  import fsc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic                         mark_i,
  input  logic                         call_i,
  input  logic                         ret_i,
  input  logic [WIDTH-1:0]             push_data_i,
  input  logic [WIDTH-1:0]             call_target_i,
  input  logic [WIDTH-1:0]             ret_addr_i,
  output logic [WIDTH-1:0]             pop_data_o,
  output logic                         pop_valid_o,
  output logic [$clog2(DEPTH+1)-1:0]   sp_o,
  output logic [WIDTH-1:0]             pc_o,
  output logic                         pc_valid_o,
  output logic                         ovf_o,
  output logic                         udf_o
);
  localparam int IW = $clog2(DEPTH + 1);

  stk_op_e          op;
  logic [IW-1:0]    sp_q, fp_q, waddr, wlink, frm_link;
  logic [WIDTH-1:0] wval, top_val, frm_val;
  logic             we_val, we_link, ovf, udf, pop_ok, pc_ok;

  fsc_decode u_decode (
    .push_i (push_i),
    .pop_i  (pop_i),
    .mark_i (mark_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .op_o   (op)
  );

  fsc_ptr #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IW(IW)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .push_data_i (push_data_i),
    .ret_addr_i  (ret_addr_i),
    .frm_link_i  (frm_link),
    .sp_o        (sp_q),
    .fp_o        (fp_q),
    .we_val_o    (we_val),
    .we_link_o   (we_link),
    .waddr_o     (waddr),
    .wval_o      (wval),
    .wlink_o     (wlink),
    .ovf_o       (ovf),
    .udf_o       (udf),
    .pop_ok_o    (pop_ok),
    .pc_ok_o     (pc_ok)
  );

  fsc_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IW(IW)) u_store (
    .clk_i       (clk_i),
    .we_val_i    (we_val),
    .we_link_i   (we_link),
    .waddr_i     (waddr),
    .wval_i      (wval),
    .wlink_i     (wlink),
    .raddr_top_i (sp_q),
    .raddr_frm_i (fp_q),
    .top_val_o   (top_val),
    .frm_val_o   (frm_val),
    .frm_link_o  (frm_link)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_data_o  <= '0;
      pop_valid_o <= 1'b0;
      pc_o        <= '0;
      pc_valid_o  <= 1'b0;
      ovf_o       <= 1'b0;
      udf_o       <= 1'b0;
    end else begin
      pop_valid_o <= pop_ok;
      pc_valid_o  <= pc_ok;
      ovf_o       <= ovf;
      udf_o       <= udf;
      if (pop_ok) pop_data_o <= top_val;
      if (pc_ok)  pc_o <= (op == OP_CALL) ? call_target_i : frm_val;
    end
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/frame_stack_ctl_chk.sv
module frame_stack_ctl_chk #(
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic          mark_i,
  input logic          call_i,
  input logic          ret_i,
  input logic [IW-1:0] sp_i,
  input logic [IW-1:0] fp_i,
  input logic          ovf_i,
  input logic          udf_i,
  input logic          pc_valid_i,
  input logic          pop_valid_i
);
  localparam logic [IW-1:0] NONE = IW'(DEPTH);

  logic only_push, only_pop;
  assign only_push = push_i && !pop_i && !mark_i && !call_i && !ret_i;
  assign only_pop  = pop_i && !mark_i && !call_i && !ret_i;

  // R2
  sp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_i <= NONE);

  // R2
  push_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_push && sp_i != '0) |=> (sp_i == $past(sp_i) - 1'b1));

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_push && sp_i == '0) |=> (ovf_i && sp_i == '0 && !pop_valid_i));

  // R4
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_pop && sp_i == NONE) |=> (udf_i && sp_i == NONE && !pop_valid_i));

  // R8
  ret_unwind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && fp_i != NONE) |=> (pc_valid_i && sp_i == $past(fp_i) + 1'b1));

  // R9
  ret_noframe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && fp_i == NONE) |=> (udf_i && !pc_valid_i && $stable(sp_i)));

  // R7
  call_noframe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && fp_i == NONE) |=> (!pc_valid_i && !udf_i && $stable(sp_i)));

  // R10
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_i, udf_i, pc_valid_i, pop_valid_i}));
endmodule

bind frame_stack_ctl frame_stack_ctl_chk #(.DEPTH(DEPTH), .IW($clog2(DEPTH + 1))) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .mark_i      (mark_i),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .sp_i        (sp_o),
  .fp_i        (fp_q),
  .ovf_i       (ovf_o),
  .udf_i       (udf_o),
  .pc_valid_i  (pc_valid_o),
  .pop_valid_i (pop_valid_o)
);

// File: tb/frame_stack_ctl_bench.sv
module frame_stack_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 16;
  localparam int IW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic push, pop, mark, call, ret;
  logic [WIDTH-1:0] push_data, call_target, ret_addr;
  logic [WIDTH-1:0] pop_data, pc;
  logic pop_valid, pc_valid, ovf, udf;
  logic [IW-1:0] sp;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state
  logic [WIDTH-1:0] m_val[$];
  int               m_link[$];
  int               m_fp = DEPTH;
  logic [WIDTH-1:0] e_pop_data = '0, e_pc = '0;
  logic             e_pop_valid = 0, e_pc_valid = 0, e_ovf = 0, e_udf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_stack_ctl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_frame_stack_ctl (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .push_i        (push),
    .pop_i         (pop),
    .mark_i        (mark),
    .call_i        (call),
    .ret_i         (ret),
    .push_data_i   (push_data),
    .call_target_i (call_target),
    .ret_addr_i    (ret_addr),
    .pop_data_o    (pop_data),
    .pop_valid_o   (pop_valid),
    .sp_o          (sp),
    .pc_o          (pc),
    .pc_valid_o    (pc_valid),
    .ovf_o         (ovf),
    .udf_o         (udf)
  );

  function automatic int m_sp();
    return DEPTH - m_val.size();
  endfunction

  // one clock of the behavioural model, applying the R10 priority
  function automatic void model_step();
    e_pop_valid = 0; e_pc_valid = 0; e_ovf = 0; e_udf = 0;
    if (ret) begin
      if (m_fp == DEPTH) e_udf = 1;
      else begin
        int pos = DEPTH - 1 - m_fp;
        int outer = m_link[pos];
        e_pc = m_val[pos];
        e_pc_valid = 1;
        while (m_val.size() > pos) begin
          void'(m_val.pop_back());
          void'(m_link.pop_back());
        end
        m_fp = outer;
      end
    end else if (call) begin
      if (m_fp != DEPTH) begin
        m_val[DEPTH - 1 - m_fp] = ret_addr;
        e_pc = call_target;
        e_pc_valid = 1;
      end
    end else if (mark) begin
      if (m_val.size() == DEPTH) e_ovf = 1;
      else begin
        m_val.push_back('0);
        m_link.push_back(m_fp);
        m_fp = m_sp();
      end
    end else if (pop) begin
      if (m_val.size() == 0 || m_fp == m_sp()) e_udf = 1;
      else begin
        e_pop_data = m_val.pop_back();
        void'(m_link.pop_back());
        e_pop_valid = 1;
      end
    end else if (push) begin
      if (m_val.size() == DEPTH) e_ovf = 1;
      else begin
        m_val.push_back(push_data);
        m_link.push_back(DEPTH);
      end
    end
  endfunction

  task automatic compare(input string tag);
    n_checks++;
    if (sp !== IW'(m_sp()) || pop_data !== e_pop_data || pop_valid !== e_pop_valid ||
        pc !== e_pc || pc_valid !== e_pc_valid || ovf !== e_ovf || udf !== e_udf) begin
      n_fail++;
      $display("FAIL %s: got sp=%0d pd=%h pv=%b pc=%h pcv=%b ovf=%b udf=%b exp sp=%0d pd=%h pv=%b pc=%h pcv=%b ovf=%b udf=%b",
               tag, sp, pop_data, pop_valid, pc, pc_valid, ovf, udf,
               m_sp(), e_pop_data, e_pop_valid, e_pc, e_pc_valid, e_ovf, e_udf);
    end
  endtask

  task automatic step(input logic p, input logic po, input logic m, input logic c,
                      input logic r, input logic [WIDTH-1:0] d,
                      input logic [WIDTH-1:0] tgt, input logic [WIDTH-1:0] ra,
                      input string tag);
    @(negedge clk);
    push = p; pop = po; mark = m; call = c; ret = r;
    push_data = d; call_target = tgt; ret_addr = ra;
    @(posedge clk);
    model_step();
    @(negedge clk);
    push = 0; pop = 0; mark = 0; call = 0; ret = 0;
    compare(tag);
  endtask

  task automatic do_push(input logic [WIDTH-1:0] d, input string tag);
    step(1, 0, 0, 0, 0, d, '0, '0, tag);
  endtask
  task automatic do_pop(input string tag);
    step(0, 1, 0, 0, 0, '0, '0, '0, tag);
  endtask
  task automatic do_mark(input string tag);
    step(0, 0, 1, 0, 0, '0, '0, '0, tag);
  endtask
  task automatic do_call(input logic [WIDTH-1:0] tgt, input logic [WIDTH-1:0] ra, input string tag);
    step(0, 0, 0, 1, 0, '0, tgt, ra, tag);
  endtask
  task automatic do_ret(input string tag);
    step(0, 0, 0, 0, 1, '0, '0, '0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    push = 0; pop = 0; mark = 0; call = 0; ret = 0;
    push_data = '0; call_target = '0; ret_addr = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: LIFO order
    do_push(16'h00a1, "R2");
    do_push(16'h00b2, "R2");
    do_push(16'h00c3, "R2");
    do_pop("R2");
    do_pop("R2");
    do_pop("R2");
    // R4: empty pop
    do_pop("R4");

    // R3: fill, then overflow on push and mark
    for (int i = 0; i < DEPTH; i++) do_push(WIDTH'(16'h1000 + i), "R2");
    do_push(16'hdead, "R3");
    do_mark("R3");
    for (int i = 0; i < DEPTH; i++) do_pop("R2");

    // R7, R9: linkage with no open frame
    do_call(16'h0300, 16'h0055, "R7");
    do_ret("R9");

    // R5, R6: mark, parameters, call, callee pops parameters
    do_mark("R5");
    do_push(16'h0011, "R5");
    do_push(16'h0022, "R5");
    do_call(16'h0100, 16'h0042, "R6");
    do_pop("R6");
    do_pop("R6");
    do_pop("R4");
    do_ret("R8");

    // R8: nested frames unwind in order
    do_push(16'h0777, "R2");
    do_mark("R5");
    do_call(16'h0200, 16'h0010, "R6");
    do_push(16'h0005, "R2");
    do_mark("R5");
    do_call(16'h0400, 16'h0020, "R6");
    do_push(16'h0009, "R2");
    do_ret("R8");
    do_pop("R8");
    do_ret("R8");
    do_pop("R8");
    do_pop("R4");

    // R10: overlapping strobes
    do_push(16'h0007, "R10");
    step(1, 1, 0, 0, 0, 16'h0008, '0, '0, "R10");
    step(1, 0, 1, 0, 0, 16'h0009, '0, '0, "R10");
    step(0, 0, 1, 1, 0, '0, 16'h0500, 16'h0060, "R10");
    step(1, 1, 1, 1, 1, 16'h000a, 16'h0600, 16'h0070, "R10");
    do_ret("R9");
    do_pop("R10");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule